// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds a word of parallel data and sends it out one bit per shift, the most significant stage first. Every pin is treated as asynchronous to the system clock. A two-flop synchronizer brings each pin into the system clock domain. The block combines the shift clock and an active-low enable with a logical OR. A detected rising edge of that combined level moves every stage one place toward the output. On that move the serial input enters the first stage.

An active-low load input overrides shift and hold. While the load input is low, the register keeps tracking the parallel inputs. Releasing the load never counts as a clock edge. The output pin carries the last stage, and a second pin carries its complement. Tying the output of one instance to the serial input of the next builds a longer parallel-to-serial converter. In that case all instances share the clock, enable and load pins.

Top module: `piso_shift_unit`

## Requirements
- R1: During synchronous active-high reset all stages clear to zero, so `serOut` is 0 after reset. The combined clock history is set high, so no shift follows the release of reset.
- R2: While `loadN` is low, stage i copies `parIn[i]` on every cycle. `parIn[WIDTH-1]` maps to the last stage. A change of `parIn` during load therefore reaches `serOut`.
- R3: While `loadN` is low, edges on `shiftClk` or `clkEnN` do not shift the register.
- R4: While `loadN` is high and `clkEnN` is low, each rising edge of `shiftClk` moves stage i to stage i+1, and `serialIn` enters stage 0.
- R5: While `clkEnN` is high, edges on `shiftClk` leave the register unchanged.
- R6: A rising edge of `clkEnN` while `shiftClk` is low shifts the register exactly as a clock edge does.
- R7: If the combined clock is high when `loadN` rises, the release of load causes no shift.
- R8: `serOutN` is always the inverse of `serOut`.
- R9: Two chained instances loaded with 16 bits give the downstream last stage first, down to the upstream stage 0. After that, the upstream serial input appears on the output.
- R10: A falling edge of the combined clock never shifts. Each rising edge shifts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| shiftClk | input | 1 | shift clock, rising edge active |
| clkEnN | input | 1 | clock enable, active low; ORed with shiftClk |
| loadN | input | 1 | parallel load, active low, level sensitive |
| serialIn | input | 1 | serial data into stage 0 |
| parIn | input | WIDTH | parallel data, bit i to stage i |
| serOut | output | 1 | last stage |
| serOutN | output | 1 | complement of last stage |

## Verification
The bench uses the default parameters: an 8-bit width and two synchronizer stages. With these, each pin change reaches the output three system clocks later, and the bench waits four clocks before every sample. It builds two instances as a 16-bit chain. This brings the cross-instance timing into reach: the downstream instance must capture the upstream last stage from before the shared edge. The full output order can then be scored against a queue of expected bits.

// File: rtl/piso_pkg.sv
package piso_pkg;

  // Strobes from control to datapath; at most one is high in a cycle.
  typedef struct packed {
    logic loadEn;   // copy parallel data into all stages
    logic shiftEn;  // move every stage one place toward the output
  } piso_strobes_t;

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RESET_VAL;
          else     chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RESET_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shiftClk,
  input  logic             clkEnN,
  input  logic             loadN,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output piso_strobes_t    strobes,
  output logic [WIDTH-1:0] syncedPar,
  output logic             syncedSer
);

  localparam int CTRL_BITS = 3;
  localparam int DATA_BITS = WIDTH + 1;

  logic [CTRL_BITS-1:0] ctrlSync;
  logic [DATA_BITS-1:0] dataSync;
  logic combinedClk;
  logic prevCombined;
  logic loadActive;

  // Control pins come out of reset in their idle state: clock high, enable off, load off.
  piso_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH(CTRL_BITS),
    .RESET_VAL({CTRL_BITS{1'b1}})
  ) uCtrlSync (
    .clk(clk),
    .rst(rst),
    .asyncIn({loadN, clkEnN, shiftClk}),
    .syncOut(ctrlSync)
  );

  piso_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH(DATA_BITS),
    .RESET_VAL({DATA_BITS{1'b0}})
  ) uDataSync (
    .clk(clk),
    .rst(rst),
    .asyncIn({serialIn, parIn}),
    .syncOut(dataSync)
  );

  assign combinedClk = ctrlSync[0] | ctrlSync[1];
  assign loadActive  = ~ctrlSync[2];
  assign syncedPar   = dataSync[WIDTH-1:0];
  assign syncedSer   = dataSync[WIDTH];

  // Edge history is pinned high during load and reset, so a release never acts as an edge.
  always_ff @(posedge clk) begin
    if (rst || loadActive) prevCombined <= 1'b1;
    else                   prevCombined <= combinedClk;
  end

  always_comb begin
    strobes.loadEn  = loadActive;
    strobes.shiftEn = ~loadActive & combinedClk & ~prevCombined;
  end

endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  piso_strobes_t    strobes,
  input  logic [WIDTH-1:0] syncedPar,
  input  logic             syncedSer,
  output logic             lastStage
);

  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] stageNext;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic fromLeft;
      if (i == 0) begin : g_head
        assign fromLeft = syncedSer;
      end else begin : g_body
        assign fromLeft = stages[i-1];
      end

      always_comb begin
        if (strobes.loadEn)       stageNext[i] = syncedPar[i];
        else if (strobes.shiftEn) stageNext[i] = fromLeft;
        else                      stageNext[i] = stages[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= stageNext;
  end

  assign lastStage = stages[WIDTH-1];

endmodule

// File: rtl/piso_shift_unit.sv
module piso_shift_unit
  import piso_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shiftClk,
  input  logic             clkEnN,
  input  logic             loadN,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut,
  output logic             serOutN
);

  piso_strobes_t strobes;
  logic [WIDTH-1:0] syncedPar;
  logic syncedSer;
  logic lastStage;

  piso_ctrl #(
    .WIDTH(WIDTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk),
    .rst(rst),
    .shiftClk(shiftClk),
    .clkEnN(clkEnN),
    .loadN(loadN),
    .serialIn(serialIn),
    .parIn(parIn),
    .strobes(strobes),
    .syncedPar(syncedPar),
    .syncedSer(syncedSer)
  );

  piso_datapath #(
    .WIDTH(WIDTH)
  ) uPath (
    .clk(clk),
    .rst(rst),
    .strobes(strobes),
    .syncedPar(syncedPar),
    .syncedSer(syncedSer),
    .lastStage(lastStage)
  );

  assign serOut  = lastStage;
  assign serOutN = ~lastStage;

endmodule

// File: rtl/piso_checker.sv
module piso_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             loadEn,
  input logic             shiftEn,
  input logic [WIDTH-1:0] syncedPar,
  input logic             serOut,
  input logic             serOutN
);

  // R8
  a_r8_complement: assert property (@(posedge clk) disable iff (rst)
    serOut != serOutN);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !serOut);

  // R2
  a_r2_load_tracks: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> serOut == $past(syncedPar[WIDTH-1]));

  // R5
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !shiftEn) |=> $stable(serOut));

  // R10
  a_r10_single_shift: assert property (@(posedge clk) disable iff (rst)
    shiftEn |=> !shiftEn);

endmodule

bind piso_shift_unit piso_checker #(.WIDTH(WIDTH)) uChk (
  .clk(clk),
  .rst(rst),
  .loadEn(strobes.loadEn),
  .shiftEn(strobes.shiftEn),
  .syncedPar(syncedPar),
  .serOut(serOut),
  .serOutN(serOutN)
);

// File: tb/sim_piso_shift_unit.sv
module sim_piso_shift_unit;

  localparam int WIDTH = 8;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shiftClk = 1'b0;
  logic clkEnN = 1'b1;
  logic loadN = 1'b1;
  logic serialIn = 1'b0;
  logic [WIDTH-1:0] parA = '0;
  logic [WIDTH-1:0] parB = '0;
  logic outA, outAN, outB, outBN;

  int checks = 0;
  int errors = 0;
  bit expQ[$];
  event doSample;
  bit monitorDone = 1'b0;

  always #2 clk = ~clk;

  piso_shift_unit #(.WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .shiftClk(shiftClk), .clkEnN(clkEnN),
    .loadN(loadN), .serialIn(serialIn), .parIn(parA),
    .serOut(outA), .serOutN(outAN)
  );

  piso_shift_unit #(.WIDTH(WIDTH)) u1 (
    .clk(clk), .rst(rst), .shiftClk(shiftClk), .clkEnN(clkEnN),
    .loadN(loadN), .serialIn(outA), .parIn(parB),
    .serOut(outB), .serOutN(outBN)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic checkA(input string req, input logic exp);
    check(req, outA, exp);
    check("R8", outAN, ~outA);
  endtask

  task automatic pulseClk();
    shiftClk = 1'b1; step(SETTLE);
    shiftClk = 1'b0; step(SETTLE);
  endtask

  // Scoreboard monitor: pops one expected bit per sample request.
  initial begin
    forever begin
      @(doSample);
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: actual=%b expected=<empty queue>", outB);
      end else begin
        bit e;
        e = expQ.pop_front();
        check("R9", outB, e);
        check("R8", outBN, ~outB);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(5);
    rst = 1'b0;
    step(SETTLE);
    checkA("R1", 1'b0);
    check("R1", outB, 1'b0);

    // R2: load tracks parallel data continuously
    loadN = 1'b0; parA = 8'h80; step(SETTLE);
    checkA("R2", 1'b1);
    parA = 8'h00; step(SETTLE);
    checkA("R2", 1'b0);
    parA = 8'h80; step(SETTLE);

    // R3: clock edges during load do nothing
    clkEnN = 1'b0;
    pulseClk(); pulseClk();
    checkA("R3", 1'b1);

    // R7: release with combined clock high does not shift
    shiftClk = 1'b1; step(SETTLE);
    loadN = 1'b1; step(SETTLE);
    checkA("R7", 1'b1);
    shiftClk = 1'b0; step(SETTLE);
    checkA("R10", 1'b1);

    // R4: shift order and serial entry
    loadN = 1'b0; parA = 8'h00; serialIn = 1'b1; step(SETTLE);
    loadN = 1'b1; step(SETTLE);
    for (int k = 1; k <= WIDTH; k++) begin
      pulseClk();
      checkA("R4", (k == WIDTH) ? 1'b1 : 1'b0);
    end

    // R5: enable high holds
    clkEnN = 1'b1;
    loadN = 1'b0; parA = 8'h80; step(SETTLE);
    loadN = 1'b1; step(SETTLE);
    pulseClk(); pulseClk(); pulseClk();
    checkA("R5", 1'b1);

    // R6: enable acts as clock while shiftClk low
    clkEnN = 1'b0; step(SETTLE);
    checkA("R10", 1'b1);
    clkEnN = 1'b1; step(SETTLE);
    checkA("R6", 1'b0);

    // R9: chained 16-bit stream
    parA = 8'h3C; parB = 8'hA9; serialIn = 1'b1;
    loadN = 1'b0; step(SETTLE);
    loadN = 1'b1; step(SETTLE);
    clkEnN = 1'b0; step(SETTLE);
    for (int b = WIDTH - 1; b >= 0; b--) expQ.push_back(parB[b]);
    for (int b = WIDTH - 1; b >= 0; b--) expQ.push_back(parA[b]);
    expQ.push_back(1'b1);
    -> doSample; step(1);
    for (int k = 0; k < 2 * WIDTH; k++) begin
      shiftClk = 1'b1; step(SETTLE);
      -> doSample; step(1);
      shiftClk = 1'b0; step(SETTLE);
    end
    monitorDone = 1'b1;
    check("R9", (expQ.size() == 0) ? 1'b1 : 1'b0, 1'b1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule